// File: doc/BRIEF.md
# Halving Tree Reduction Sequencer

This block adds up a long stream of unsigned words by treating a register array as a set of lanes, each holding one partial sum. After a start strobe, the input words arrive in index order on a valid-qualified stream. Each lane collects one contiguous block of them: word `k` goes to lane `k / BLOCK`. A gap in the stream stalls the accumulation without losing anything.

When the last word of the last lane has been taken, the block runs a series of folding steps, one per clock cycle. A live-lane count starts at the number of lanes. On each step the upper half of the live lanes is added onto the lower half, and the count is halved with integer division. When the count is odd, lane 0 also takes in the lane that the halving leaves stranded. All lane updates of a step are written at the same clock edge, and that edge is the barrier between steps. The reduction stops when one live lane remains, and lane 0 then holds the grand total. A done flag and a step counter report completion.

Top module: `halving_reduce`

## Requirements
- R1: After reset, `total` is 0, `done` is 0 and `step_count` is 0.
- R2: During accumulation, each accepted word with stream index `k` (counted from 0 since the start strobe) is added to lane `k / BLOCK`. At completion, `total` equals the sum of all `LANES*BLOCK` accepted words.
- R3: Sums are `DW + clog2(LANES*BLOCK)` bits wide, and no total overflows, even when every word is at its maximum value.
- R4: Each folding step halves the live count with integer division, starting from `LANES`. At completion, `step_count` equals floor(log2(`LANES`)).
- R5: On a step where the live count `n` is odd, lane 0 also adds in lane `n-1`, on top of its regular partner lane `n/2`.
- R6: `done` goes high on the clock edge that commits the final step and stays high until the next accepted start strobe, which clears it.
- R7: A start strobe that arrives while accumulation or folding is in progress is ignored.
- R8: `in_valid` has no effect outside accumulation, including while `done` is high.
- R9: Each folding step takes exactly one cycle. `done` reads 1 exactly floor(log2(`LANES`)) clock edges after the edge that accepts the last word.
- R10: Cycles with `in_valid` low during accumulation stall the stream without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a new reduction when idle; ignored while busy |
| in_valid | input | 1 | Marks `in_data` as the next word in index order |
| in_data | input | DW | Unsigned input word |
| total | output | DW+clog2(LANES*BLOCK) | Content of lane 0; the grand total once `done` is high |
| done | output | 1 | Reduction complete; held until the next start |
| step_count | output | clog2(floor(log2(LANES))+2) | Number of folding steps committed in the current run |

## Verification
The bench builds the block with six lanes of three words each and 8-bit data. This makes the live count go 6, 3, 1, so one run contains both an even step and an odd step where lane 0 absorbs a stranded lane. With only 18 inputs, the bench can sweep a distinct marker value through every input index, which shows that each index reaches the total along its particular fold path. It also runs saturated data, stream gaps, a start strobe in the middle of a run, and input traffic while done is high.

// File: rtl/hr_pkg.sv
package hr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_FOLD  = 2'd2
  } hr_state_t;

  // Live lanes remaining after one folding step.
  function automatic int halve_live(input int n);
    return n / 2;
  endfunction

  // Number of folding steps needed to go from n live lanes to one.
  function automatic int fold_steps(input int n);
    int c;
    int m;
    c = 0;
    m = n;
    while (m > 1) begin
      m = m / 2;
      c = c + 1;
    end
    return c;
  endfunction

  // Result width that cannot overflow for `count` words of `dw` bits.
  function automatic int sum_width(input int dw, input int count);
    return dw + $clog2(count);
  endfunction

endpackage

// File: rtl/hr_feed.sv
module hr_feed #(
  parameter int LANES = 100,
  parameter int BLOCK = 1000,
  parameter int LW    = 7,
  parameter int BW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  output logic [LW-1:0] lane_idx,
  output logic          last_word
);

  logic [BW-1:0] word_idx;
  logic          block_end;

  assign block_end = (word_idx == BW'(BLOCK - 1));
  assign last_word = block_end && (lane_idx == LW'(LANES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_idx <= '0;
      word_idx <= '0;
    end else if (clear) begin
      lane_idx <= '0;
      word_idx <= '0;
    end else if (take) begin
      if (block_end) begin
        word_idx <= '0;
        lane_idx <= last_word ? '0 : lane_idx + 1'b1;
      end else begin
        word_idx <= word_idx + 1'b1;
      end
    end
  end

  // R2: the lane pointer never leaves the lane array
  assert_lane_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lane_idx <= LW'(LANES - 1));

  // R2: finishing a lane moves the pointer on to the next lane
  assert_lane_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && block_end && !last_word && !clear) |=> lane_idx == $past(lane_idx) + 1'b1);

endmodule

// File: rtl/hr_ctrl.sv
module hr_ctrl #(
  parameter int LANES = 100,
  parameter int LVW   = 7,
  parameter int CW    = 3,
  parameter int STEPS = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           in_valid,
  input  logic           last_word,
  output logic           clear,
  output logic           acc_en,
  output logic           fold_en,
  output logic [LVW-1:0] live,
  output logic           done,
  output logic [CW-1:0]  step_count
);

  import hr_pkg::*;

  hr_state_t      state;
  logic [LVW-1:0] live_nx;

  assign clear   = start && (state == ST_IDLE);
  assign acc_en  = in_valid && (state == ST_ACCUM);
  assign fold_en = (state == ST_FOLD);
  assign live_nx = LVW'(halve_live(int'(live)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      live       <= LVW'(LANES);
      done       <= 1'b0;
      step_count <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state      <= ST_ACCUM;
            live       <= LVW'(LANES);
            done       <= 1'b0;
            step_count <= '0;
          end
        end
        ST_ACCUM: begin
          if (acc_en && last_word) begin
            if (LANES == 1) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_FOLD;
            end
          end
        end
        ST_FOLD: begin
          live       <= live_nx;
          step_count <= step_count + 1'b1;
          if (live_nx == LVW'(1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: done holds until a start strobe
  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R4: a completed run has performed exactly floor(log2(LANES)) steps
  assert_step_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> step_count == CW'(STEPS));

  // R9: every folding cycle commits exactly one step
  assert_one_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fold_en |=> step_count == $past(step_count) + 1'b1);

  // R7: a start strobe during folding does not disturb the sequence
  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_en && start) |=> (step_count != '0));

endmodule

// File: rtl/hr_lanes.sv
module hr_lanes #(
  parameter int LANES = 100,
  parameter int DW    = 16,
  parameter int SW    = 33,
  parameter int LW    = 7,
  parameter int LVW   = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           acc_en,
  input  logic [LW-1:0]  acc_lane,
  input  logic [DW-1:0]  acc_data,
  input  logic           fold_en,
  input  logic [LVW-1:0] live,
  output logic [SW-1:0]  lane0
);

  logic [SW-1:0]  sums [LANES];
  logic [LVW-1:0] half;
  logic           odd;
  logic [SW-1:0]  stray;

  assign half  = live >> 1;
  assign odd   = live[0];
  assign lane0 = sums[0];

  // Lane left over by an odd live count, absorbed by lane 0.
  always_comb begin
    stray = '0;
    for (int k = 0; k < LANES; k++) begin
      if (odd && (k == int'(live) - 1)) stray = sums[k];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SW-1:0] acc;
    logic [SW-1:0] partner;
    logic          folds;

    assign folds = LVW'(i) < half;

    always_comb begin
      partner = '0;
      for (int k = 0; k < LANES; k++) begin
        if (k == i + int'(half)) partner = sums[k];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc <= '0;
      end else if (clear) begin
        acc <= '0;
      end else if (acc_en && (acc_lane == LW'(i))) begin
        acc <= acc + SW'(acc_data);
      end else if (fold_en && folds) begin
        if (i == 0) acc <= acc + partner + stray;
        else        acc <= acc + partner;
      end
    end

    assign sums[i] = acc;
  end

  // R3: folding only adds, so lane 0 never wraps downward
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fold_en |=> sums[0] >= $past(sums[0]));

  // R8: with no accumulation, fold or clear, lane 0 keeps its value
  assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !acc_en && !fold_en) |=> $stable(sums[0]));

  // R5: an odd fold into lane 0 takes in at least the stranded lane
  assert_odd_absorb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_en && odd) |=> sums[0] >= $past(sums[0]) + $past(stray));

endmodule

// File: rtl/halving_reduce.sv
module halving_reduce #(
  parameter int LANES = 100,
  parameter int BLOCK = 1000,
  parameter int DW    = 16,
  localparam int SW    = hr_pkg::sum_width(DW, LANES * BLOCK),
  localparam int STEPS = hr_pkg::fold_steps(LANES),
  localparam int CW    = $clog2(STEPS + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic [SW-1:0] total,
  output logic          done,
  output logic [CW-1:0] step_count
);

  localparam int LW  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int BW  = (BLOCK > 1) ? $clog2(BLOCK) : 1;
  localparam int LVW = $clog2(LANES + 1);

  logic           clear;
  logic           acc_en;
  logic           fold_en;
  logic           last_word;
  logic [LW-1:0]  lane_idx;
  logic [LVW-1:0] live;

  hr_ctrl #(.LANES(LANES), .LVW(LVW), .CW(CW), .STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .last_word(last_word), .clear(clear), .acc_en(acc_en),
    .fold_en(fold_en), .live(live), .done(done), .step_count(step_count)
  );

  hr_feed #(.LANES(LANES), .BLOCK(BLOCK), .LW(LW), .BW(BW)) u_feed (
    .clk(clk), .rst_n(rst_n), .clear(clear), .take(acc_en),
    .lane_idx(lane_idx), .last_word(last_word)
  );

  hr_lanes #(.LANES(LANES), .DW(DW), .SW(SW), .LW(LW), .LVW(LVW)) u_lanes (
    .clk(clk), .rst_n(rst_n), .clear(clear), .acc_en(acc_en),
    .acc_lane(lane_idx), .acc_data(in_data), .fold_en(fold_en),
    .live(live), .lane0(total)
  );

  // R1: nothing is reported as complete right after a start
  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!done && step_count == '0));

endmodule

// File: tb/halving_reduce_test.sv
`timescale 1ns/1ps
module halving_reduce_test;

  localparam int LANES = 6;
  localparam int BLOCK = 3;
  localparam int DW    = 8;
  localparam int N     = LANES * BLOCK;
  localparam int SW    = DW + $clog2(N);
  localparam int STEPS = 2;       // 6 -> 3 -> 1
  localparam int CW    = $clog2(STEPS + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [SW-1:0] total;
  logic          done;
  logic [CW-1:0] step_count;

  int checks = 0;
  int fails  = 0;
  int words [N];

  always #2 clk = ~clk;   // 250 MHz

  halving_reduce #(.LANES(LANES), .BLOCK(BLOCK), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_data(in_data), .total(total), .done(done), .step_count(step_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expected_sum();
    int s = 0;
    for (int k = 0; k < N; k++) s += words[k];
    return s;
  endfunction

  // Run one reduction; returns the edge count from last word to done.
  task automatic run(input int gap, input bit poke, output int lat);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < N; k++) begin
      in_valid = 1'b1;
      in_data  = DW'(words[k]);
      start    = poke && (k == 7);
      @(negedge clk);
      start = 1'b0;
      for (int g = 0; g < gap; g++) begin
        in_valid = 1'b0;
        in_data  = 8'hA5;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    lat = 0;
    if (poke) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 total", int'(total), 0);
    check("R1 done", int'(done), 0);
    check("R1 step_count", int'(step_count), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: every word at maximum
    for (int k = 0; k < N; k++) words[k] = 255;
    run(0, 1'b0, lat);
    check("R3 saturated total", int'(total), N * 255);
    check("R4 steps", int'(step_count), STEPS);
    check("R9 latency", lat, STEPS);
    check("R6 done", int'(done), 1);

    // R2 R5: single marker swept through every index
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < N; k++) words[k] = (k == p) ? (p * 13 + 7) : 0;
      run(0, 1'b0, lat);
      check($sformatf("R2 R5 marker at %0d", p), int'(total), expected_sum());
    end

    // R2: ramp pattern
    for (int k = 0; k < N; k++) words[k] = k + 1;
    run(0, 1'b0, lat);
    check("R2 ramp total", int'(total), expected_sum());

    // R10: gaps in the stream
    for (int k = 0; k < N; k++) words[k] = (k * 37 + 11) % 256;
    run(2, 1'b0, lat);
    check("R10 gapped total", int'(total), expected_sum());
    check("R10 steps", int'(step_count), STEPS);

    // R7: start strobes during accumulation and folding are ignored
    for (int k = 0; k < N; k++) words[k] = 200 - k * 3;
    run(0, 1'b1, lat);
    check("R7 total", int'(total), expected_sum());
    check("R7 latency", lat, STEPS);
    check("R7 steps", int'(step_count), STEPS);

    // R8 R6: input traffic while done is ignored, done stays high
    for (int c = 0; c < 6; c++) begin
      in_valid = 1'b1;
      in_data  = 8'hFF;
      @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 total unchanged", int'(total), expected_sum());
    check("R6 done held", int'(done), 1);

    // R6: an accepted start clears done
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R6 done cleared", int'(done), 0);
    check("R4 steps cleared", int'(step_count), 0);
    check("R2 lanes cleared", int'(total), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule